// File: doc/BRIEF.md
# CPU interrupt entry sequencer

This block runs the microsequence a simple 16-bit processor model executes when it leaves the current program for an interrupt handler, and the reverse sequence for the return instruction. The processor core pulses `instr_end_i` when an instruction completes. Only on that cycle does the sequencer look at its request sources: an internal or software trap with its own type number, the overflow trap instruction, an edge-latched non-maskable line, a level-sensitive maskable line and the single-step flag.

On entry it stores three words on the stack through a word-wide memory port: the flag image, the code segment and the return pointer. It then reads a two-word vector from the table at physical address 0, indexed by type times four, and loads the new pointer and segment. For the maskable line it first emits two acknowledge pulses and takes the 8-bit type from an external controller. The return operation reverses the stack stores. The surrounding core reads the architectural state on the `*_o` ports and writes the flag word through the flag write port for instructions that change flags.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle (busy_o=0, inta_o=0, mem_req_o=0) with SP, CS and FLAGS at their reset parameter values and IP at 0. Requests are acted on only on a cycle where instr_end_i=1 and busy_o=0; instr_end_i while busy_o=1 has no effect.
- R2: When several requests are present at an instruction end, the order is: trap_i (type trap_type_i), then into_i with OF set (type 4), then a latched NMI (type 2), then intr_i with IF set, then single step (type 1).
- R3: A rising edge on nmi_i is latched until taken and is taken even when IF (bit 9) is 0; a level held high produces only one entry.
- R4: intr_i has no effect while IF (bit 9) is 0.
- R5: An accepted intr_i gives exactly two one-cycle inta_o pulses with one low cycle between them; the type is taken from ext_type_i during the second pulse.
- R6: Entry writes, in this order, the flag image as it was before entry at stack offset SP-2, CS at SP-4 and the captured IP at SP-6, and leaves SP reduced by 6.
- R7: Entry clears TF (bit 8) and IF (bit 9) and keeps every other flag bit.
- R8: The new IP is read from physical address type*4 and the new CS from type*4+2.
- R9: With TF set, a type 1 entry follows each instruction end; inside the handler (TF now clear) an instruction end with no request causes no entry.
- R10: into_i with OF (bit 11) clear causes no entry and no memory access.
- R11: The return operation (iret_i with instr_end_i) reads IP at SP, CS at SP+2 and FLAGS at SP+4, and leaves SP increased by 6.
- R12: Stack addresses are STACK_SEG*16 + offset truncated to 20 bits.
- R13: Busy time after the accepting instruction end is 5 cycles for a trap, NMI or single-step entry, 8 for a maskable entry and 3 for a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_end_i | input | 1 | Current instruction completes this cycle |
| ret_ip_i | input | 16 | Pointer of the next instruction, captured at instruction end |
| iret_i | input | 1 | The completing instruction is a return from interrupt |
| trap_i | input | 1 | Internal or software trap requested by the completing instruction |
| trap_type_i | input | 8 | Type number for trap_i |
| into_i | input | 1 | The completing instruction is the overflow trap |
| flags_we_i | input | 1 | Write flag word (only while idle) |
| flags_wdata_i | input | 16 | Flag word to write |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| inta_o | output | 1 | Acknowledge pulse to the external controller |
| ext_type_i | input | 8 | Type number supplied by the external controller |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Physical byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid in the cycle of the request |
| busy_o | output | 1 | Sequence in progress |
| flags_o | output | 16 | Flag register |
| cs_o | output | 16 | Code segment register |
| ip_o | output | 16 | Instruction pointer register |
| sp_o | output | 16 | Stack pointer register |

## Verification
Every result is tied to the edge that samples `instr_end_i`: busy_o rises one cycle later and falls 5, 8 or 3 cycles after that, and the registers hold their final values on the first cycle with busy_o low. The bench drives each boundary for exactly one cycle, counts busy cycles at the falling clock edge and compares the count with R13 before it reads the stack log, SP, FLAGS, CS and IP. Acknowledge pulses and stack writes are logged on the rising edges where they take effect. The external type is presented wrong during the first pulse and right from the gap onward, so a sequencer that samples it on the wrong pulse loads the wrong vector.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK1,
    ST_ACK_GAP,
    ST_ACK2,
    ST_PUSH_F,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_F
  } seq_state_e;

  // flag bit positions seen in the pushed image
  localparam int FLAG_TF = 8;
  localparam int FLAG_IF = 9;
  localparam int FLAG_OF = 11;

  localparam int TYPE_STEP = 1;
  localparam int TYPE_NMI  = 2;
  localparam int TYPE_OVF  = 4;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);

  logic lvl_q;
  logic pend_q;
  logic rise;

  assign rise   = lvl_i & ~lvl_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  // R3
  nmi_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && !lvl_q) |=> pend_o);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_entry_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              eval_i,
  input  logic              trap_i,
  input  logic [TYPE_W-1:0] trap_type_i,
  input  logic              ovf_trap_i,
  input  logic              of_i,
  input  logic              nmi_pend_i,
  input  logic              intr_i,
  input  logic              if_i,
  input  logic              tf_i,
  output logic              vec_go_o,
  output logic              ack_go_o,
  output logic              nmi_take_o,
  output logic [TYPE_W-1:0] type_o
);

  always_comb begin
    vec_go_o   = 1'b0;
    ack_go_o   = 1'b0;
    nmi_take_o = 1'b0;
    type_o     = '0;
    if (eval_i) begin
      if (trap_i) begin
        vec_go_o = 1'b1;
        type_o   = trap_type_i;
      end else if (ovf_trap_i && of_i) begin
        vec_go_o = 1'b1;
        type_o   = TYPE_W'(TYPE_OVF);
      end else if (nmi_pend_i) begin
        vec_go_o   = 1'b1;
        nmi_take_o = 1'b1;
        type_o     = TYPE_W'(TYPE_NMI);
      end else if (intr_i && if_i) begin
        ack_go_o = 1'b1;
      end else if (tf_i) begin
        vec_go_o = 1'b1;
        type_o   = TYPE_W'(TYPE_STEP);
      end
    end
  end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vec_go_i,
  input  logic       ack_go_i,
  input  logic       ret_go_i,
  output seq_state_e state_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_go_i)      state_d = ST_POP_IP;
        else if (vec_go_i) state_d = ST_PUSH_F;
        else if (ack_go_i) state_d = ST_ACK1;
      end
      ST_ACK1:    state_d = ST_ACK_GAP;
      ST_ACK_GAP: state_d = ST_ACK2;
      ST_ACK2:    state_d = ST_PUSH_F;
      ST_PUSH_F:  state_d = ST_PUSH_CS;
      ST_PUSH_CS: state_d = ST_PUSH_IP;
      ST_PUSH_IP: state_d = ST_VEC_LO;
      ST_VEC_LO:  state_d = ST_VEC_HI;
      ST_VEC_HI:  state_d = ST_IDLE;
      ST_POP_IP:  state_d = ST_POP_CS;
      ST_POP_CS:  state_d = ST_POP_F;
      ST_POP_F:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/irq_phys_addr.sv
module irq_phys_addr #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [DATA_W-1:0] seg_i,
  input  logic [DATA_W-1:0] off_i,
  output logic [ADDR_W-1:0] addr_o
);

  // carry out of the top bit is dropped (wraps)
  assign addr_o = ADDR_W'({seg_i, {SEG_SHIFT{1'b0}}}) + ADDR_W'(off_i);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int                 DATA_W    = 16,
  parameter int                 ADDR_W    = 20,
  parameter int                 TYPE_W    = 8,
  parameter int                 SEG_SHIFT = 4,
  parameter logic [DATA_W-1:0]  STACK_SEG = 'h0100,
  parameter logic [DATA_W-1:0]  SP_RST    = 'h0100,
  parameter logic [DATA_W-1:0]  CS_RST    = 'hF000,
  parameter logic [DATA_W-1:0]  FLAGS_RST = 'h0002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_end_i,
  input  logic [DATA_W-1:0] ret_ip_i,
  input  logic              iret_i,
  input  logic              trap_i,
  input  logic [TYPE_W-1:0] trap_type_i,
  input  logic              into_i,
  input  logic              flags_we_i,
  input  logic [DATA_W-1:0] flags_wdata_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  output logic              inta_o,
  input  logic [TYPE_W-1:0] ext_type_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] flags_o,
  output logic [DATA_W-1:0] cs_o,
  output logic [DATA_W-1:0] ip_o,
  output logic [DATA_W-1:0] sp_o
);

  localparam int                WORD_BYTES = DATA_W / 8;
  localparam int                VEC_SHIFT  = $clog2(2 * WORD_BYTES);
  localparam logic [DATA_W-1:0] STEP       = DATA_W'(WORD_BYTES);

  seq_state_e        state;
  logic              idle, eval, ret_go;
  logic              vec_go, ack_go, nmi_take, nmi_pend;
  logic [TYPE_W-1:0] arb_type;
  logic              in_push, in_pop, in_vec;
  logic [DATA_W-1:0] sp_dec, seg_sel, off_sel, vec_off;

  logic [DATA_W-1:0] flags_q, cs_q, ip_q, sp_q;
  logic [TYPE_W-1:0] type_q;

  assign idle   = (state == ST_IDLE);
  assign eval   = idle & instr_end_i & ~iret_i;
  assign ret_go = idle & instr_end_i & iret_i;

  irq_edge_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (nmi_i),
    .clr_i  (nmi_take),
    .pend_o (nmi_pend)
  );

  irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
    .eval_i      (eval),
    .trap_i      (trap_i),
    .trap_type_i (trap_type_i),
    .ovf_trap_i  (into_i),
    .of_i        (flags_q[FLAG_OF]),
    .nmi_pend_i  (nmi_pend),
    .intr_i      (intr_i),
    .if_i        (flags_q[FLAG_IF]),
    .tf_i        (flags_q[FLAG_TF]),
    .vec_go_o    (vec_go),
    .ack_go_o    (ack_go),
    .nmi_take_o  (nmi_take),
    .type_o      (arb_type)
  );

  irq_entry_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vec_go_i (vec_go),
    .ack_go_i (ack_go),
    .ret_go_i (ret_go),
    .state_o  (state)
  );

  assign in_push = (state == ST_PUSH_F) || (state == ST_PUSH_CS) || (state == ST_PUSH_IP);
  assign in_pop  = (state == ST_POP_IP) || (state == ST_POP_CS) || (state == ST_POP_F);
  assign in_vec  = (state == ST_VEC_LO) || (state == ST_VEC_HI);
  assign sp_dec  = sp_q - STEP;
  assign vec_off = (DATA_W'(type_q) << VEC_SHIFT) + ((state == ST_VEC_HI) ? STEP : '0);

  // vector table lives in segment 0
  assign seg_sel = in_vec ? '0 : STACK_SEG;
  assign off_sel = in_push ? sp_dec : (in_pop ? sp_q : vec_off);

  irq_phys_addr #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_addr (
    .seg_i  (seg_sel),
    .off_i  (off_sel),
    .addr_o (mem_addr_o)
  );

  always_comb begin
    unique case (state)
      ST_PUSH_F:  mem_wdata_o = flags_q;
      ST_PUSH_CS: mem_wdata_o = cs_q;
      default:    mem_wdata_o = ip_q;
    endcase
  end

  assign mem_req_o = in_push | in_pop | in_vec;
  assign mem_we_o  = in_push;
  assign inta_o    = (state == ST_ACK1) || (state == ST_ACK2);
  assign busy_o    = ~idle;
  assign flags_o   = flags_q;
  assign cs_o      = cs_q;
  assign ip_o      = ip_q;
  assign sp_o      = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= FLAGS_RST;
      cs_q    <= CS_RST;
      ip_q    <= '0;
      sp_q    <= SP_RST;
      type_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (flags_we_i) flags_q <= flags_wdata_i;
          if (eval)       ip_q    <= ret_ip_i;
          if (vec_go)     type_q  <= arb_type;
        end
        ST_ACK2: type_q <= ext_type_i;
        ST_PUSH_F: begin
          flags_q[FLAG_IF] <= 1'b0;
          flags_q[FLAG_TF] <= 1'b0;
          sp_q             <= sp_dec;
        end
        ST_PUSH_CS, ST_PUSH_IP: sp_q <= sp_dec;
        ST_VEC_LO: ip_q <= mem_rdata_i;
        ST_VEC_HI: cs_q <= mem_rdata_i;
        ST_POP_IP: begin
          ip_q <= mem_rdata_i;
          sp_q <= sp_q + STEP;
        end
        ST_POP_CS: begin
          cs_q <= mem_rdata_i;
          sp_q <= sp_q + STEP;
        end
        ST_POP_F: begin
          flags_q <= mem_rdata_i;
          sp_q    <= sp_q + STEP;
        end
        default: ;
      endcase
    end
  end

  // R1
  no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_end_i && !busy_o) |=> !busy_o);

  // R4
  intr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ACK1) |-> $past(flags_o[FLAG_IF]));

  // R5
  inta_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> !inta_o);

  // R6
  push_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> (sp_o == $past(sp_o) - STEP));

  // R7
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PUSH_F) |=> (!flags_o[FLAG_IF] && !flags_o[FLAG_TF]));

  // R11
  pop_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_POP_IP) |=> (sp_o == $past(sp_o) + STEP));

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  localparam logic [15:0] SSEG  = 16'hFFF8;
  localparam logic [15:0] SPRST = 16'h0800;

  // {kind, type, flags}: kind 0 trap, 1 overflow trap, 2 maskable, 3 nmi
  localparam logic [25:0] TBL [7] = '{
    {2'd0, 8'h00, 16'h0302},
    {2'd0, 8'h03, 16'h0002},
    {2'd1, 8'h99, 16'h0A02},
    {2'd2, 8'h20, 16'h0202},
    {2'd2, 8'hFF, 16'h0F02},
    {2'd3, 8'h00, 16'h0002},
    {2'd0, 8'h80, 16'h08D7}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_end = 1'b0, iret = 1'b0, trap = 1'b0, into = 1'b0;
  logic [15:0] ret_ip = '0;
  logic [7:0]  trap_type = '0;
  logic        flags_we = 1'b0;
  logic [15:0] flags_wdata = '0;
  logic        nmi = 1'b0, intr = 1'b0;
  logic [7:0]  ext_type;
  logic        inta_o, mem_req_o, mem_we_o, busy_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata;
  logic [15:0] flags_o, cs_o, ip_o, sp_o;

  always #2 clk = ~clk;

  irq_entry_seq #(.STACK_SEG(SSEG), .SP_RST(SPRST)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .instr_end_i(instr_end), .ret_ip_i(ret_ip),
    .iret_i(iret), .trap_i(trap), .trap_type_i(trap_type), .into_i(into),
    .flags_we_i(flags_we), .flags_wdata_i(flags_wdata), .nmi_i(nmi), .intr_i(intr),
    .inta_o(inta_o), .ext_type_i(ext_type), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata),
    .busy_o(busy_o), .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o)
  );

  int checks = 0, errors = 0;
  logic [15:0] stk [128];
  logic [19:0] wl_addr [16];
  logic [15:0] wl_data [16];
  int wtot = 0, inta_tot = 0, wbase = 0, inta_base = 0;
  logic [7:0] good_type = 8'h00;

  // memory: vector table computed, stack stored
  always_comb begin
    if (mem_addr_o < 20'h00400)
      mem_rdata = mem_addr_o[1] ? {8'hC0, mem_addr_o[9:2]} : {8'h40, mem_addr_o[9:2]};
    else
      mem_rdata = stk[mem_addr_o[7:1]];
  end

  always @(posedge clk) begin
    if (rst_ni && mem_req_o && mem_we_o) begin
      stk[mem_addr_o[7:1]] = mem_wdata_o;
      wl_addr[wtot % 16]   = mem_addr_o;
      wl_data[wtot % 16]   = mem_wdata_o;
      wtot++;
    end
    if (rst_ni && inta_o) inta_tot++;
  end

  // wrong type until the first acknowledge has been seen
  always @(negedge clk) ext_type = ((inta_tot - inta_base) != 0) ? good_type : ~good_type;

  logic [15:0] m_sp = SPRST, m_cs = 16'hF000, m_ip = '0, m_fl = 16'h0002;
  logic [15:0] sv_ip [8], sv_cs [8], sv_fl [8];
  int depth = 0;
  logic done = 1'b0;

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return 20'({seg, 4'b0000}) + 20'(off);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic set_flags(input logic [15:0] v);
    @(negedge clk);
    flags_we = 1'b1; flags_wdata = v;
    @(negedge clk);
    flags_we = 1'b0;
    m_fl = v;
  endtask

  task automatic op(input logic tr, input logic [7:0] tt, input logic ov, input logic rt,
                    input logic [15:0] ipv, output int bc);
    @(negedge clk);
    wbase = wtot; inta_base = inta_tot;
    instr_end = 1'b1; trap = tr; trap_type = tt; into = ov; iret = rt; ret_ip = ipv;
    if (!rt) m_ip = ipv;
    @(negedge clk);
    instr_end = 1'b0; trap = 1'b0; into = 1'b0; iret = 1'b0;
    bc = 0;
    while (busy_o && bc < 40) begin bc++; @(negedge clk); end
  endtask

  task automatic check_entry(input logic [7:0] t, input int bc, input int bexp, input int iexp);
    chk("R13 busy cycles", bc, bexp);
    chk("R5 ack pulses", inta_tot - inta_base, iexp);
    chk("R6 write count", wtot - wbase, 3);
    chk("R6 R12 flags addr", wl_addr[(wbase + 0) % 16], phys(SSEG, m_sp - 16'd2));
    chk("R6 flags data", wl_data[(wbase + 0) % 16], m_fl);
    chk("R6 R12 cs addr", wl_addr[(wbase + 1) % 16], phys(SSEG, m_sp - 16'd4));
    chk("R6 cs data", wl_data[(wbase + 1) % 16], m_cs);
    chk("R6 R12 ip addr", wl_addr[(wbase + 2) % 16], phys(SSEG, m_sp - 16'd6));
    chk("R6 ip data", wl_data[(wbase + 2) % 16], m_ip);
    sv_ip[depth] = m_ip; sv_cs[depth] = m_cs; sv_fl[depth] = m_fl; depth++;
    m_sp = m_sp - 16'd6;
    m_fl = m_fl & ~16'h0300;
    m_ip = {8'h40, t};
    m_cs = {8'hC0, t};
    chk("R6 sp", sp_o, m_sp);
    chk("R7 flags", flags_o, m_fl);
    chk("R8 new ip", ip_o, m_ip);
    chk("R8 new cs", cs_o, m_cs);
  endtask

  task automatic do_ret();
    int bc;
    op(1'b0, 8'h00, 1'b0, 1'b1, 16'h0000, bc);
    depth--;
    m_ip = sv_ip[depth]; m_cs = sv_cs[depth]; m_fl = sv_fl[depth];
    m_sp = m_sp + 16'd6;
    chk("R13 return busy", bc, 3);
    chk("R11 sp", sp_o, m_sp);
    chk("R11 ip", ip_o, m_ip);
    chk("R11 cs", cs_o, m_cs);
    chk("R11 flags", flags_o, m_fl);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R13 watchdog act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 inta", inta_o, 0);
    chk("R1 mem_req", mem_req_o, 0);
    chk("R1 sp", sp_o, SPRST);
    chk("R1 cs", cs_o, 16'hF000);
    chk("R1 flags", flags_o, 16'h0002);
    chk("R1 ip", ip_o, 16'h0000);

    // table walk
    for (int i = 0; i < 7; i++) begin
      logic [1:0]  kind;
      logic [7:0]  ty, texp;
      kind = TBL[i][25:24];
      ty   = TBL[i][23:16];
      set_flags(TBL[i][15:0]);
      texp = (kind == 2'd1) ? 8'd4 : (kind == 2'd3) ? 8'd2 : ty;
      if (kind == 2'd2) begin good_type = ty; intr = 1'b1; end
      if (kind == 2'd3) begin @(negedge clk); nmi = 1'b1; end
      op(kind == 2'd0, ty, kind == 2'd1, 1'b0, 16'h2000 + 16'(i * 16'h0111), bc);
      intr = 1'b0; nmi = 1'b0;
      check_entry(texp, bc, (kind == 2'd2) ? 8 : 5, (kind == 2'd2) ? 2 : 0);
      do_ret();
    end

    // R1: requests without an instruction end are not taken
    set_flags(16'h0302);
    intr = 1'b1; trap = 1'b1; good_type = 8'h41;
    repeat (4) @(negedge clk);
    chk("R1 idle without instr end", busy_o, 0);
    trap = 1'b0;
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3100, bc);
    intr = 1'b0;
    check_entry(8'h41, bc, 8, 2);
    do_ret();

    // R1: instruction end while busy is ignored
    set_flags(16'h0002);
    @(negedge clk);
    wbase = wtot; inta_base = inta_tot;
    instr_end = 1'b1; trap = 1'b1; trap_type = 8'h11; ret_ip = 16'h5555; m_ip = 16'h5555;
    @(negedge clk);
    trap_type = 8'h33;
    repeat (2) @(negedge clk);
    instr_end = 1'b0; trap = 1'b0;
    bc = 0;
    while (busy_o && bc < 40) begin bc++; @(negedge clk); end
    check_entry(8'h11, bc, 3, 0);
    @(negedge clk);
    chk("R1 no second entry", busy_o, 0);
    do_ret();

    // R4: masked maskable request
    set_flags(16'h0002);
    intr = 1'b1; good_type = 8'h40;
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3300, bc);
    chk("R4 masked busy", bc, 0);
    chk("R4 masked ack", inta_tot - inta_base, 0);
    chk("R4 masked ip", ip_o, 16'h3300);
    set_flags(16'h0202);
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3302, bc);
    intr = 1'b0;
    check_entry(8'h40, bc, 8, 2);
    do_ret();

    // R10: overflow trap with OF clear
    set_flags(16'h0202);
    op(1'b0, 8'h00, 1'b1, 1'b0, 16'h3400, bc);
    chk("R10 busy", bc, 0);
    chk("R10 writes", wtot - wbase, 0);
    chk("R10 ip", ip_o, 16'h3400);

    // R3: held level gives one entry, IF clear does not block it
    set_flags(16'h0002);
    @(negedge clk); nmi = 1'b1;
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3500, bc);
    check_entry(8'h02, bc, 5, 0);
    do_ret();
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3502, bc);
    chk("R3 held level no repeat", bc, 0);
    nmi = 1'b0;

    // R2: all sources at once, resolved in order
    set_flags(16'h0B02);
    @(negedge clk); nmi = 1'b1; intr = 1'b1; good_type = 8'h50;
    op(1'b1, 8'h21, 1'b1, 1'b0, 16'h3600, bc);
    check_entry(8'h21, bc, 5, 0);
    do_ret();
    op(1'b0, 8'h00, 1'b1, 1'b0, 16'h3602, bc);
    check_entry(8'h04, bc, 5, 0);
    do_ret();
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3604, bc);
    check_entry(8'h02, bc, 5, 0);
    do_ret();
    nmi = 1'b0;
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3606, bc);
    intr = 1'b0;
    check_entry(8'h50, bc, 8, 2);
    do_ret();

    // R9: single step each instruction, handler itself not stepped
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h3608, bc);
    check_entry(8'h01, bc, 5, 0);
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h4000, bc);
    chk("R9 handler not stepped", bc, 0);
    do_ret();
    op(1'b0, 8'h00, 1'b0, 1'b0, 16'h360A, bc);
    check_entry(8'h01, bc, 5, 0);
    do_ret();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule